// File: doc/BRIEF.md
# Double-Buffered Quad-Word Link Port

This block is a point-to-point link port that carries wide quad words over a narrow byte lane with a forwarded strobe. On the transmit side, a holding buffer feeds a shift register, which serializes the word onto the lane. On the receive side, a shift register assembles the incoming beats and then hands the finished word to a receive buffer. Each direction therefore keeps two words in flight. The port raises one request line to the DMA channel that feeds it and another to the DMA channel that drains it. The DMA engines sit outside this block.

Words enter through a valid/ready write interface, which only accepts while the transmit channel is enabled and the holding buffer is empty. Words leave through a valid/ready read interface. Valid is shown only while the receive channel is enabled and the receive buffer holds a word. A stalled consumer holds `rx_ready` low. The word and `rx_valid` then stay put, and back-pressure ripples back through the receive shift register and across the link, until `tx_ready` drops.

Across the link, the receiver raises a credit line only while its shift register is empty. The sender starts a word only while that line is high. Once started, it sends every beat of the word on consecutive cycles, lowest lane first. All link signals are synchronous to `clk`, and the strobe marks each valid beat.

Top module: `lnk_port`

## Requirements
- R1: Reset has these effects. Both buffers and both shift registers become empty. `lnk_clk_out` is low. `lnk_fc_out` is high. `tx_req`, `rx_req` and `rx_valid` are low.
- R2: `tx_req` and `tx_ready` are high exactly when `tx_chan_en` is high and the holding buffer is empty. This holds in the same cycle the enable rises. A write offered while `tx_chan_en` is low is ignored.
- R3: A held word moves into the transmit shift register on the first edge at which that register is empty. That move empties the holding buffer, so `tx_req` rises again one cycle after an accepted write.
- R4: Each loaded word is sent as QW_BITS/LANE_BITS beats, with `lnk_clk_out` high on consecutive cycles. Beat k carries bits [k*LANE_BITS +: LANE_BITS], so bits [LANE_BITS-1:0] go first. Every word that enters the shift register is sent.
- R5: The receiver assembles beats in arrival order into the same bit positions. `rx_valid` and `rx_req` are high exactly when `rx_chan_en` is high and the receive buffer is full. `rx_data` stays stable until it is taken by `rx_valid && rx_ready`.
- R6: The receive shift register accepts beats only while it is not holding a complete word. A complete word waits there until the receive buffer is empty, and is then copied across. `lnk_fc_out` is high only while the shift register is empty and no word is partly received.
- R7: The transmitter starts a word only when `lnk_fc_in` is high. Otherwise it pauses between words.
- R8: With reads stalled, the port holds four words: the holding buffer, the transmit shift register, the receive shift register and the receive buffer. After that, `tx_ready` stays low. Words come out in the order they were written.
- R9: While `rx_chan_en` is low, a full receive buffer keeps its word, and `rx_valid` and `rx_req` stay low. Once the channel is enabled, the same word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_chan_en | input | 1 | Transmit DMA channel enabled |
| tx_valid | input | 1 | Write word offered |
| tx_data | input | QW_BITS | Write word |
| tx_ready | output | 1 | Holding buffer accepts the word |
| tx_req | output | 1 | Request to the transmit DMA channel |
| rx_chan_en | input | 1 | Receive DMA channel enabled |
| rx_valid | output | 1 | Received word available |
| rx_data | output | QW_BITS | Received word |
| rx_ready | input | 1 | Consumer takes the word |
| rx_req | output | 1 | Request to the receive DMA channel |
| lnk_dout | output | LANE_BITS | Outgoing link lane |
| lnk_clk_out | output | 1 | Outgoing beat strobe |
| lnk_fc_in | input | 1 | Credit from the far receiver (high = may start a word) |
| lnk_din | input | LANE_BITS | Incoming link lane |
| lnk_clk_in | input | 1 | Incoming beat strobe |
| lnk_fc_out | output | 1 | Credit to the far sender |

## Verification
The bench builds the port with 32-bit words and an 8-bit lane, so one word takes four beats. It loops the link outputs back into the inputs. With words this short, many combinations of write gaps and read stalls fit in one run. Filling all four storage stages, and checking every beat's lane order and credit, takes only a few dozen cycles per scenario.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_phase_e;
endpackage

// File: rtl/lnk_tx.sv
module lnk_tx
  import lnk_pkg::*;
#(
  parameter int QW_BITS   = 128,
  parameter int LANE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chan_en,
  input  logic                 wr_valid,
  input  logic [QW_BITS-1:0]   wr_data,
  output logic                 wr_ready,
  output logic                 req,
  input  logic                 fc_in,
  output logic [LANE_BITS-1:0] lane_out,
  output logic                 stb_out
);
  localparam int BEATS = QW_BITS / LANE_BITS;
  localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  logic [QW_BITS-1:0] hold_q, shift_q;
  logic               hold_full, shift_full;
  tx_phase_e          phase;
  logic [CW-1:0]      beat;
  logic               take, move;

  assign req      = chan_en && !hold_full;
  assign wr_ready = req;
  assign take     = wr_valid && wr_ready;
  assign move     = hold_full && !shift_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_full  <= 1'b0;
      shift_q    <= '0;
      shift_full <= 1'b0;
      phase      <= TX_IDLE;
      beat       <= '0;
      lane_out   <= '0;
      stb_out    <= 1'b0;
    end else begin
      if (take) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end else if (move) begin
        hold_full <= 1'b0;
      end
      if (move) begin
        shift_q    <= hold_q;
        shift_full <= 1'b1;
      end
      case (phase)
        TX_IDLE: begin
          if (shift_full && fc_in) begin
            phase    <= TX_SEND;
            beat     <= '0;
            lane_out <= shift_q[LANE_BITS-1:0];
            stb_out  <= 1'b1;
            shift_q  <= shift_q >> LANE_BITS;
          end
        end
        TX_SEND: begin
          if (beat == LAST) begin
            phase      <= TX_IDLE;
            stb_out    <= 1'b0;
            shift_full <= 1'b0;
          end else begin
            beat     <= beat + 1'b1;
            lane_out <= shift_q[LANE_BITS-1:0];
            stb_out  <= 1'b1;
            shift_q  <= shift_q >> LANE_BITS;
          end
        end
        default: phase <= TX_IDLE;
      endcase
    end
  end

  // R2: an accepted write fills the holding buffer, so the next cycle refuses
  p_hold_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !wr_ready);
  // R3: a held word leaves for an empty shift register at the next edge
  p_move_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !shift_full) |=> !hold_full);
  // R7: no new word starts without credit from the far receiver
  p_start_needs_credit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == TX_IDLE && !fc_in) |=> !stb_out);
  // R4: beats of one word go out on consecutive cycles
  p_beats_contiguous_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == TX_SEND && beat != LAST) |=> stb_out);
endmodule

// File: rtl/lnk_rx.sv
module lnk_rx #(
  parameter int QW_BITS   = 128,
  parameter int LANE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chan_en,
  output logic                 rd_valid,
  output logic [QW_BITS-1:0]   rd_data,
  input  logic                 rd_ready,
  output logic                 req,
  input  logic [LANE_BITS-1:0] lane_in,
  input  logic                 stb_in,
  output logic                 fc_out
);
  localparam int BEATS = QW_BITS / LANE_BITS;
  localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  logic [QW_BITS-1:0] asm_q, buf_q;
  logic               asm_full, buf_full;
  logic [CW-1:0]      cnt;
  logic               copy, pop, accept;

  assign rd_valid = chan_en && buf_full;
  assign req      = rd_valid;
  assign rd_data  = buf_q;
  assign pop      = rd_valid && rd_ready;
  assign copy     = asm_full && !buf_full;
  assign accept   = stb_in && !asm_full;
  assign fc_out   = !asm_full && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asm_q    <= '0;
      asm_full <= 1'b0;
      cnt      <= '0;
      buf_q    <= '0;
      buf_full <= 1'b0;
    end else begin
      if (accept) begin
        asm_q <= {lane_in, asm_q[QW_BITS-1:LANE_BITS]};
        if (cnt == LAST) begin
          cnt      <= '0;
          asm_full <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (copy) begin
        buf_q    <= asm_q;
        buf_full <= 1'b1;
        asm_full <= 1'b0;
      end else if (pop) begin
        buf_full <= 1'b0;
      end
    end
  end

  // R6: the sender never strobes a beat into an occupied shift register
  p_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_in |-> !asm_full);
  // R6: a complete word stays in the shift register while the buffer is occupied
  p_wait_for_buffer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (asm_full && buf_full && !pop) |=> asm_full);
  // R5: a presented word is held until taken
  p_hold_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (buf_full && $stable(buf_q)));
endmodule

// File: rtl/lnk_port.sv
module lnk_port #(
  parameter int QW_BITS   = 128,
  parameter int LANE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_chan_en,
  input  logic                 tx_valid,
  input  logic [QW_BITS-1:0]   tx_data,
  output logic                 tx_ready,
  output logic                 tx_req,
  input  logic                 rx_chan_en,
  output logic                 rx_valid,
  output logic [QW_BITS-1:0]   rx_data,
  input  logic                 rx_ready,
  output logic                 rx_req,
  output logic [LANE_BITS-1:0] lnk_dout,
  output logic                 lnk_clk_out,
  input  logic                 lnk_fc_in,
  input  logic [LANE_BITS-1:0] lnk_din,
  input  logic                 lnk_clk_in,
  output logic                 lnk_fc_out
);
  lnk_tx #(.QW_BITS(QW_BITS), .LANE_BITS(LANE_BITS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_en  (tx_chan_en),
    .wr_valid (tx_valid),
    .wr_data  (tx_data),
    .wr_ready (tx_ready),
    .req      (tx_req),
    .fc_in    (lnk_fc_in),
    .lane_out (lnk_dout),
    .stb_out  (lnk_clk_out)
  );

  lnk_rx #(.QW_BITS(QW_BITS), .LANE_BITS(LANE_BITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_en  (rx_chan_en),
    .rd_valid (rx_valid),
    .rd_data  (rx_data),
    .rd_ready (rx_ready),
    .req      (rx_req),
    .lane_in  (lnk_din),
    .stb_in   (lnk_clk_in),
    .fc_out   (lnk_fc_out)
  );
endmodule

// File: tb/lnk_port_test.sv
module lnk_port_test;
  localparam int QW = 32;
  localparam int LN = 8;
  localparam int NB = QW / LN;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, tx_chan_en, tx_valid, tx_ready, tx_req;
  logic [QW-1:0] tx_data, rx_data;
  logic          rx_chan_en, rx_valid, rx_ready, rx_req;
  logic [LN-1:0] lnk_dout;
  logic          lnk_clk_out, lnk_fc_out;

  lnk_port #(.QW_BITS(QW), .LANE_BITS(LN)) uut (
    .clk(clk), .rst_n(rst_n),
    .tx_chan_en(tx_chan_en), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_req(tx_req),
    .rx_chan_en(rx_chan_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_req(rx_req),
    .lnk_dout(lnk_dout), .lnk_clk_out(lnk_clk_out), .lnk_fc_in(lnk_fc_out),
    .lnk_din(lnk_dout), .lnk_clk_in(lnk_clk_out), .lnk_fc_out(lnk_fc_out)
  );

  int checks = 0, errors = 0;
  int nsent = 0, nrecv = 0;
  logic [QW-1:0] expq [0:511];
  bit done = 0;

  function automatic logic [QW-1:0] pat(int i);
    logic [QW-1:0] r;
    for (int k = 0; k < NB; k++) r[k*LN +: LN] = LN'((i * 37 + k * 11 + 5) & 255);
    return r;
  endfunction

  task automatic chk(bit ok, string what, logic [QW-1:0] act, logic [QW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // link monitor: lane order, contiguity and credit (R4, R7)
  int bcnt = 0, widx = 0, stb_seen = 0;
  logic last_fc = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (lnk_clk_out) begin
        stb_seen++;
        if (bcnt == 0) chk(last_fc, "R7 word start needs credit", QW'(last_fc), 1);
        chk(lnk_dout == expq[widx][bcnt*LN +: LN], "R4 lane order",
            QW'(lnk_dout), QW'(expq[widx][bcnt*LN +: LN]));
        bcnt++;
        if (bcnt == NB) begin
          bcnt = 0;
          widx++;
        end
      end else if (bcnt != 0) begin
        chk(1'b0, "R4 beats contiguous", 0, 1);
      end
      last_fc = lnk_fc_out;
    end
  end

  task automatic send(logic [QW-1:0] w);
    @(negedge clk);
    tx_data  = w;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    expq[nsent] = w;
    nsent++;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic recv(string what);
    logic [QW-1:0] w;
    @(negedge clk);
    rx_ready = 1'b1;
    while (!rx_valid) @(negedge clk);
    w = rx_data;
    chk(w == expq[nrecv], what, w, expq[nrecv]);
    nrecv++;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; tx_chan_en = 1'b0; tx_valid = 1'b0; tx_data = '0;
    rx_chan_en = 1'b0; rx_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(tx_req == 1'b0, "R1 tx_req after reset", QW'(tx_req), 0);
    chk(rx_req == 1'b0 && rx_valid == 1'b0, "R1 rx idle after reset", QW'(rx_req), 0);
    chk(lnk_clk_out == 1'b0, "R1 strobe low after reset", QW'(lnk_clk_out), 0);
    chk(lnk_fc_out == 1'b1, "R1 credit high after reset", QW'(lnk_fc_out), 1);
    rst_n = 1'b1;

    // R2: writes ignored while the channel is disabled
    tx_data = pat(999); tx_valid = 1'b1;
    repeat (10) @(negedge clk);
    chk(tx_ready == 1'b0, "R2 no ready while disabled", QW'(tx_ready), 0);
    chk(stb_seen == 0, "R2 disabled write not sent", QW'(stb_seen), 0);
    tx_valid = 1'b0;
    @(negedge clk);
    tx_chan_en = 1'b1;
    #1 chk(tx_req == 1'b1, "R2 request in the enable cycle", QW'(tx_req), 1);
    rx_chan_en = 1'b1;

    // R3: holding buffer frees one cycle after a write
    send(pat(0));
    chk(tx_req == 1'b0, "R3 buffer full right after write", QW'(tx_req), 0);
    @(negedge clk);
    chk(tx_req == 1'b1, "R3 buffer freed by move", QW'(tx_req), 1);
    recv("R5 single word");

    // R8: four-deep back-pressure, order preserved
    for (int i = 1; i <= 4; i++) send(pat(i));
    repeat (40) @(negedge clk);
    chk(tx_ready == 1'b0, "R8 full after four words", QW'(tx_ready), 0);
    chk(lnk_fc_out == 1'b0, "R6 credit low with word held", QW'(lnk_fc_out), 0);
    chk(rx_valid == 1'b1 && rx_data == pat(1), "R8 oldest word presented", rx_data, pat(1));
    fork
      send(pat(5));
    join_none
    repeat (20) @(negedge clk);
    chk(nsent == 5, "R8 fifth write stalled", QW'(nsent), 5);
    for (int i = 0; i < 5; i++) recv("R8 drain order");

    // R9: receive channel disabled holds the word
    rx_chan_en = 1'b0;
    send(pat(50));
    repeat (40) @(negedge clk);
    chk(rx_valid == 1'b0 && rx_req == 1'b0, "R9 no valid while disabled", QW'(rx_valid), 0);
    rx_ready = 1'b1;
    repeat (5) @(negedge clk);
    rx_ready = 1'b0;
    rx_chan_en = 1'b1;
    #1 chk(rx_req == 1'b1 && rx_data == pat(50), "R9 word kept", rx_data, pat(50));
    recv("R9 word read after enable");

    // R5/R6 sweep over write gaps and read stalls
    for (int r = 0; r < 6; r++) begin
      fork
        begin
          for (int i = 0; i < 12; i++) begin
            send(pat(100 + r * 20 + i));
            repeat ((i * 5 + r) % 7) @(negedge clk);
          end
        end
        begin
          for (int i = 0; i < 12; i++) begin
            recv("R5 sweep data");
            repeat ((i * 3 + r * 2) % 9) @(negedge clk);
          end
        end
      join
    end

    repeat (10) @(negedge clk);
    chk(widx == nsent && bcnt == 0, "R4 every word sent", QW'(widx), QW'(nsent));
    chk(nrecv == nsent, "R5 every word received", QW'(nrecv), QW'(nsent));
    done = 1;
    finish_run();
  end
endmodule